// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block sits beside a two-port memory. It observes, on each port, an enable, a write request and an address. When both ports are enabled on the same address it picks one winner. It then raises a busy flag toward the losing port, one clock after the clash is first seen. Each port gets a write-allow output. That output is the port's enabled write request, blocked while the port's busy flag is active.

A mode input lets several copies be cascaded to build a wider word. In master mode the block arbitrates and drives its busy outputs. In slave mode the busy outputs stay low. The write-allow outputs are then gated by busy inputs that come from a master copy, so every slice of a wide word obeys the same decision.

The winner is chosen by incumbency: a port that already sat on the address keeps it. When both ports arrive in the same cycle, the left port wins. A decision holds until the contention ends.

Top module: `dpbusy_arb`

## Requirements
- R1: During and right after reset, both busy outputs are 0.
- R2: Contention exists only when both enables are 1 and the two addresses are equal. In any cycle without contention, both internal busy flags are 0 after the next clock edge.
- R3: In master mode (master_mode=1), a cycle with contention makes exactly one of l_busy_out or r_busy_out equal to 1 after the next clock edge.
- R4: If neither port was enabled on its current address in the previous cycle, or if both were, the left port wins (r_busy_out=1), unless a decision is already being held.
- R5: If exactly one port was enabled on its current address in the previous cycle, that port wins and the other port gets busy.
- R6: While contention continues with both addresses unchanged, the winner stays the same. Busy clears one clock after contention ends.
- R7: In master mode the busy inputs are ignored. The busy outputs carry the arbitration result, and that result gates the write-allow outputs.
- R8: In slave mode (master_mode=0), both busy outputs are 0. l_busy_in and r_busy_in act as each port's busy flag.
- R9: A port's write-allow output equals enable AND write request AND NOT that port's effective busy, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = master (arbitrate), 0 = slave (use busy inputs) |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write request |
| l_addr | input | AW | Left port address |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write request |
| r_addr | input | AW | Right port address |
| l_busy_in | input | 1 | Left busy from a master (slave mode) |
| r_busy_in | input | 1 | Right busy from a master (slave mode) |
| l_busy_out | output | 1 | Left busy result (master mode) |
| r_busy_out | output | 1 | Right busy result (master mode) |
| l_wr_ok | output | 1 | Left write allowed |
| r_wr_ok | output | 1 | Right write allowed |

## Verification
A stale or wrong winner register shows up at the ports one cycle after a clash. It appears as busy on the wrong side, and the matching write-allow turns off in the same cycle. A wrong remembered enable or address shows up only when a newcomer joins an incumbent. So the stimulus includes an incumbent joined by a newcomer, a same-cycle arrival, and a joint move to a new address. Mode handling is checked by toggling the busy inputs in both modes and watching the write-allow outputs.

// File: rtl/dpbusy_arb.sv
module dpbusy_arb #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic          l_busy_in,
  input  logic          r_busy_in,
  output logic          l_busy_out,
  output logic          r_busy_out,
  output logic          l_wr_ok,
  output logic          r_wr_ok
);

  logic          pl_en, pr_en;
  logic [AW-1:0] pl_addr, pr_addr;
  logic          lb_q, rb_q;
  logic          lb_d, rb_d;

  wire clash  = l_en && r_en && (l_addr == r_addr);
  wire l_stay = pl_en && (pl_addr == l_addr);
  wire r_stay = pr_en && (pr_addr == r_addr);
  wire held   = (lb_q || rb_q) && l_stay && r_stay;

  always_comb begin
    lb_d = 1'b0;
    rb_d = 1'b0;
    if (master_mode && clash) begin
      if (held) begin
        lb_d = lb_q;
        rb_d = rb_q;
      end else if (r_stay && !l_stay) begin
        lb_d = 1'b1;
      end else begin
        rb_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_en   <= 1'b0;
      pr_en   <= 1'b0;
      pl_addr <= '0;
      pr_addr <= '0;
      lb_q    <= 1'b0;
      rb_q    <= 1'b0;
    end else begin
      pl_en   <= l_en;
      pr_en   <= r_en;
      pl_addr <= l_addr;
      pr_addr <= r_addr;
      lb_q    <= lb_d;
      rb_q    <= rb_d;
    end
  end

  wire l_busy_eff = master_mode ? lb_q : l_busy_in;
  wire r_busy_eff = master_mode ? rb_q : r_busy_in;

  assign l_busy_out = master_mode && lb_q;
  assign r_busy_out = master_mode && rb_q;
  assign l_wr_ok    = l_en && l_wr && !l_busy_eff;
  assign r_wr_ok    = r_en && r_wr && !r_busy_eff;

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_q && rb_q)); // R3
  AST_NO_CLASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !clash |=> (!lb_q && !rb_q)); // R2
  AST_CLASH_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && clash) |=> (lb_q != rb_q)); // R3
  AST_HOLD_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && clash && lb_q && l_stay && r_stay) |=> lb_q); // R6
  AST_SLAVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && r_busy_in) |-> !r_wr_ok); // R8

endmodule

// File: tb/dpbusy_arb_test.sv
module dpbusy_arb_test;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 1'b0, l_wr = 1'b0, r_en = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in = 1'b0, r_busy_in = 1'b0;
  logic l_busy_out, r_busy_out, l_wr_ok, r_wr_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];
  event sample_ev;

  always #10 clk = ~clk;

  dpbusy_arb #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  // monitor: pops expected items and compares {lbusy, rbusy, lok, rok}
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [3:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {l_busy_out, r_busy_out, l_wr_ok, r_wr_ok};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, a, e);
        end
      end
    end
  end

  // driver: apply inputs at negedge, expect outputs just after next posedge
  task automatic step(input logic ms, input logic le, input logic lw, input int la,
                      input logic re, input logic rw, input int ra,
                      input logic lbi, input logic rbi,
                      input logic [3:0] e, input string t);
    @(negedge clk);
    master_mode = ms; l_en = le; l_wr = lw; l_addr = AW'(la);
    r_en = re; r_wr = rw; r_addr = AW'(ra);
    l_busy_in = lbi; r_busy_in = rbi;
    @(posedge clk);
    #2;
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->sample_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    exp_q.push_back(4'b0000); tag_q.push_back("R1 in reset"); ->sample_ev; #1;
    @(negedge clk); rst_n = 1'b1;
    step(1, 0,0,0, 0,0,0, 0,0, 4'b0000, "R1 after reset");
    step(1, 1,1,5, 1,1,5, 0,0, 4'b0110, "R4 same-cycle arrival left wins");
    step(1, 1,1,5, 1,1,5, 0,0, 4'b0110, "R6 hold winner");
    step(1, 1,1,5, 0,1,5, 0,0, 4'b0010, "R6 clear after right leaves");
    step(1, 1,1,5, 1,1,7, 0,0, 4'b0011, "R2 different addresses");
    step(1, 1,1,7, 1,1,7, 0,0, 4'b1001, "R5 right incumbent wins");
    step(1, 1,1,7, 1,1,7, 0,0, 4'b1001, "R6 hold right winner");
    step(1, 0,1,7, 1,1,7, 0,0, 4'b0001, "R2 left disabled clears");
    step(1, 1,1,7, 1,1,7, 0,0, 4'b1001, "R5 newcomer left loses");
    step(1, 1,1,3, 1,1,3, 0,0, 4'b0110, "R4 joint move left wins");
    step(1, 1,1,4, 1,0,6, 0,0, 4'b0010, "R9 read gives no write allow");
    step(0, 1,1,3, 1,1,3, 1,0, 4'b0001, "R8 slave left busy in");
    step(0, 1,1,3, 1,1,3, 0,1, 4'b0010, "R8 slave right busy in");
    step(0, 1,1,3, 1,1,3, 1,1, 4'b0000, "R8 slave both busy in");
    step(1, 1,1,2, 1,1,8, 1,1, 4'b0011, "R7 master ignores busy in");
    step(1, 1,1,9, 1,1,9, 1,1, 4'b0110, "R3 master clash one busy");
    step(1, 1,1,1, 0,1,1, 0,0, 4'b0010, "R2 one port only no clash");
    step(1, 0,0,0, 0,0,0, 0,0, 4'b0000, "R9 idle");
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule